// File: doc/BRIEF.md
# Overlapped Radix-16 SRT Divider

This block is the iterative core of a fixed-point divider. It takes a 56-bit divisor whose top bit is set and a 56-bit dividend, and produces quotient digits from the set {-2,-1,0,1,2}. It resolves two radix-4 digits, which is four quotient bits, on every clock. The partial remainder stays in carry-save form for the whole operation. It is updated only by 3:2 compressor rows, so no carry-propagate adder sits in the loop.

To fit two radix-4 steps into one cycle, the first step builds all five next remainders in parallel, one for each possible digit. A digit selector runs on each of those five candidates, so the second digit is known in advance for every possible first digit. Once the first digit is known, multiplexers pick both the remainder and the second digit. The second step then uses the same five-candidate scheme and is resolved by the second digit.

Internally the divisor d lies in [1/2,1) and the dividend is pre-scaled by 1/4. The start value therefore meets the convergence bound |w| <= (2/3)d. The digit stream forms an integer quotient. At the end, the sign of the final remainder tells the consumer whether that quotient is one above the floor result.

Top module: `srt16_div_core`

## Requirements
- R1: While rst_ni is low, and after its release until the first accepted start, digit_vld_o and done_o are 0.
- R2: A start_i sampled high while idle begins an operation. The k-th digit pair (k = 1..P) is shown with digit_vld_o = 1 in the cycle after the k-th rising edge following the sampling edge. That gives P consecutive valid cycles.
- R3: Each digit is a 3-bit two's complement value in {-2..2}. digit_hi_o carries weight 4 and digit_lo_o carries weight 1 within the pair's 4-bit group.
- R4: done_o is high for exactly one cycle, the cycle that shows the P-th digit pair. In the next cycle, when no new start is taken, digit_vld_o and done_o are 0.
- R5: Let Qa be the sum over k of (4*hi_k + lo_k) * 16^(P-k). Then Qa - rem_neg_o equals floor(X * 4^(2P-1) / D), where X is the dividend and D is the divisor as integers.
- R6: In the done cycle, rem_neg_o is 1 exactly when X * 4^(2P-1) - Qa * D is negative.
- R7: A start_i that is high while an operation is in progress is ignored. The running result is unchanged and no extra operation follows.
- R8: The partial remainder w satisfies 3|w| <= 2d in every busy cycle and in the done cycle. As a result, |X * 4^(2P-1) - Qa * D| <= (2/3) D.
- R9: A start_i sampled in the done cycle is accepted, so operations can run back to back without an idle cycle.
- R10: Divisor bit 55 must be 1. The dividend may be any value, and a zero dividend gives Qa = 0 with rem_neg_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| dividend_i | input | 56 | Dividend X, sampled with start |
| divisor_i | input | 56 | Divisor D, top bit set, sampled with start |
| digit_vld_o | output | 1 | A digit pair is shown this cycle |
| digit_hi_o | output | 3 | First radix-4 digit of the pair, two's complement |
| digit_lo_o | output | 3 | Second radix-4 digit of the pair, two's complement |
| done_o | output | 1 | Last pair shown; remainder sign valid |
| rem_neg_o | output | 1 | Sign of the final remainder, valid with done_o |

## Verification
The operands and start are driven on a falling edge, so the sampling edge is the next rising edge. The first digit pair is due one rising edge after that, and the P-th pair, with done_o, is due P rising edges after the sampling edge. The bench walks through exactly those edges and reads every output on the falling edge that follows each one. It builds the quotient there and compares it with a wide integer floor division. Ignored and chained starts are placed at fixed positions inside that window: one cycle into the busy period, and in the done cycle itself. One more cycle is then checked to make sure nothing else starts.

// File: rtl/srt16_pkg.sv
package srt16_pkg;
  typedef logic signed [2:0] digit_t;
  // estimate: 4 integer bits (with sign) + 6 fraction bits
  localparam int EST_W  = 10;
  localparam int DTOP_W = 6;
endpackage

// File: rtl/srt_csa.sv
module srt_csa #(
  parameter int RW = 62
) (
  input  logic [RW-1:0] a_i,
  input  logic [RW-1:0] b_i,
  input  logic [RW-1:0] m_i,
  input  logic          cin_i,
  output logic [RW-1:0] s_o,
  output logic [RW-1:0] c_o
);
  logic [RW-1:0] maj;
  assign s_o = a_i ^ b_i ^ m_i;
  assign maj = (a_i & b_i) | (a_i & m_i) | (b_i & m_i);
  // free low carry slot completes the two's complement of negated multiples
  assign c_o = {maj[RW-2:0], cin_i};
endmodule

// File: rtl/srt_fan.sv
module srt_fan #(
  parameter int RW = 62
) (
  input  logic [RW-1:0]      ys_i,
  input  logic [RW-1:0]      yc_i,
  input  logic [RW-1:0]      d_i,
  output logic [4:0][RW-1:0] s_o,
  output logic [4:0][RW-1:0] c_o
);
  // slot k holds y - (k-2)*d
  for (genvar k = 0; k < 5; k++) begin : g_cand
    localparam int QV = k - 2;
    logic [RW-1:0] mult;
    logic          cin;
    if (QV > 0) begin : g_neg
      assign mult = ~(d_i << (QV - 1));
      assign cin  = 1'b1;
    end else if (QV < 0) begin : g_pos
      assign mult = d_i << (-QV - 1);
      assign cin  = 1'b0;
    end else begin : g_zero
      assign mult = '0;
      assign cin  = 1'b0;
    end
    srt_csa #(.RW(RW)) u_csa (
      .a_i  (ys_i),
      .b_i  (yc_i),
      .m_i  (mult),
      .cin_i(cin),
      .s_o  (s_o[k]),
      .c_o  (c_o[k])
    );
  end
endmodule

// File: rtl/srt_qsel.sv
module srt_qsel
  import srt16_pkg::*;
#(
  parameter int RW = 62
) (
  input  logic [RW-1:0]     ys_i,
  input  logic [RW-1:0]     yc_i,
  input  logic [DTOP_W-1:0] dtop_i,
  output digit_t            q_o
);
  logic signed [EST_W-1:0] est, m_p2, m_p1, m_z, m_n1;
  logic [8:0] t3, h1;
  logic [6:0] h0;

  always_comb begin
    est  = $signed(ys_i[RW-1 -: EST_W] + yc_i[RW-1 -: EST_W]);
    t3   = {2'b0, dtop_i, 1'b0} + {3'b0, dtop_i};
    h1   = (t3 + 9'd1) >> 1;
    h0   = ({1'b0, dtop_i} + 7'd1) >> 1;
    // thresholds in units of 1/64: floor(1.5d), floor(d/2), floor(-d/2), floor(-1.5d)
    m_p2 = $signed({2'b0, t3[8:1]});
    m_p1 = $signed({5'b0, dtop_i[DTOP_W-1:1]});
    m_z  = -$signed({3'b0, h0});
    m_n1 = -$signed({1'b0, h1});
    if      (est >= m_p2) q_o = 3'sd2;
    else if (est >= m_p1) q_o = 3'sd1;
    else if (est >= m_z)  q_o = 3'sd0;
    else if (est >= m_n1) q_o = -3'sd1;
    else                  q_o = -3'sd2;
  end
endmodule

// File: rtl/srt16_div_core.sv
module srt16_div_core
  import srt16_pkg::*;
#(
  parameter int W = 56,
  parameter int P = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [W-1:0]       dividend_i,
  input  logic [W-1:0]       divisor_i,
  output logic               digit_vld_o,
  output logic signed [2:0]  digit_hi_o,
  output logic signed [2:0]  digit_lo_o,
  output logic               done_o,
  output logic               rem_neg_o
);
  localparam int RW = W + 6;  // 4 integer bits, W+2 fraction bits
  localparam int CW = (P > 1) ? $clog2(P) : 1;

  logic          busy_q, vld_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] ws_q, wc_q, d_q;
  digit_t        hi_q, lo_q;

  logic [RW-1:0]      ys, yc, rh_s, rh_c, nxt_s, nxt_c;
  logic [4:0][RW-1:0] hs, hc, ls, lc;
  logic [DTOP_W-1:0]  dtop;
  digit_t             q_hi, q_lo;
  digit_t             ql_spec [5];

  assign dtop = d_q[W+1 -: DTOP_W];
  assign ys   = {ws_q[RW-3:0], 2'b00};
  assign yc   = {wc_q[RW-3:0], 2'b00};

  // first sub-step: all five remainders plus first digit
  srt_fan #(.RW(RW)) u_fan_hi (.ys_i(ys), .yc_i(yc), .d_i(d_q), .s_o(hs), .c_o(hc));
  srt_qsel #(.RW(RW)) u_sel_hi (.ys_i(ys), .yc_i(yc), .dtop_i(dtop), .q_o(q_hi));

  // second digit pre-selected for every first-digit candidate
  for (genvar k = 0; k < 5; k++) begin : g_spec
    srt_qsel #(.RW(RW)) u_sel_lo (
      .ys_i  ({hs[k][RW-3:0], 2'b00}),
      .yc_i  ({hc[k][RW-3:0], 2'b00}),
      .dtop_i(dtop),
      .q_o   (ql_spec[k])
    );
  end

  always_comb begin
    case (q_hi)
      3'sd2:   begin rh_s = hs[4]; rh_c = hc[4]; q_lo = ql_spec[4]; end
      3'sd1:   begin rh_s = hs[3]; rh_c = hc[3]; q_lo = ql_spec[3]; end
      -3'sd1:  begin rh_s = hs[1]; rh_c = hc[1]; q_lo = ql_spec[1]; end
      -3'sd2:  begin rh_s = hs[0]; rh_c = hc[0]; q_lo = ql_spec[0]; end
      default: begin rh_s = hs[2]; rh_c = hc[2]; q_lo = ql_spec[2]; end
    endcase
  end

  srt_fan #(.RW(RW)) u_fan_lo (
    .ys_i({rh_s[RW-3:0], 2'b00}),
    .yc_i({rh_c[RW-3:0], 2'b00}),
    .d_i (d_q),
    .s_o (ls),
    .c_o (lc)
  );

  always_comb begin
    case (q_lo)
      3'sd2:   begin nxt_s = ls[4]; nxt_c = lc[4]; end
      3'sd1:   begin nxt_s = ls[3]; nxt_c = lc[3]; end
      -3'sd1:  begin nxt_s = ls[1]; nxt_c = lc[1]; end
      -3'sd2:  begin nxt_s = ls[0]; nxt_c = lc[0]; end
      default: begin nxt_s = ls[2]; nxt_c = lc[2]; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      ws_q   <= '0;
      wc_q   <= '0;
      d_q    <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (!busy_q) begin
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(P - 1);
        ws_q   <= {6'b0, dividend_i};            // x/4
        wc_q   <= '0;
        d_q    <= {4'b0, divisor_i, 2'b00};
      end
    end else begin
      ws_q  <= nxt_s;
      wc_q  <= nxt_c;
      hi_q  <= q_hi;
      lo_q  <= q_lo;
      vld_q <= 1'b1;
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q - 1'b1;
        done_q <= 1'b0;
      end
    end
  end

  logic [RW-1:0] rsum, rmag;
  assign rsum = ws_q + wc_q;
  assign rmag = rsum[RW-1] ? (~rsum + 1'b1) : rsum;

  assign digit_vld_o = vld_q;
  assign digit_hi_o  = hi_q;
  assign digit_lo_o  = lo_q;
  assign done_o      = done_q;
  assign rem_neg_o   = rsum[RW-1];

  p_digit_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (hi_q >= -3'sd2 && hi_q <= 3'sd2 && lo_q >= -3'sd2 && lo_q <= 3'sd2));

  p_vld_after_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> $past(busy_q));

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_done_with_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (vld_q && !busy_q));

  p_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

  p_rem_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q || done_q) |-> (({2'b0, rmag} * 3) <= ({2'b0, d_q} * 2)));
endmodule

// File: tb/tb_srt16_div_core.sv
module tb_srt16_div_core;
  localparam int W = 56;
  localparam int P = 14;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W-1:0] dvd = '0, dvs = '0;
  logic vld, done, neg;
  logic signed [2:0] dh, dl;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  srt16_div_core #(.W(W), .P(P)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dividend_i(dvd), .divisor_i(dvs),
    .digit_vld_o(vld), .digit_hi_o(dh), .digit_lo_o(dl),
    .done_o(done), .rem_neg_o(neg)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit in_rng(input logic signed [2:0] v);
    return (v >= -3'sd2) && (v <= 3'sd2);
  endfunction

  // poke: start pulse one cycle into busy; chained: started in previous done cycle; hold: skip idle cycle
  task automatic do_div(input logic [W-1:0] x, input logic [W-1:0] d,
                        input bit poke, input bit chained, input bit hold);
    longint qa;
    bit ok_vld, ok_rng, ok_done, nexp;
    logic [127:0] num, qref, prod, mag;
    logic signed [127:0] rem;
    dvd = x; dvs = d; start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    qa = 0; ok_vld = 1'b1; ok_rng = 1'b1; ok_done = 1'b1;
    for (int k = 1; k <= P; k++) begin
      if (poke && k == 2) begin
        dvd = ~x; dvs = {1'b1, ~d[W-2:0]}; start = 1'b1;
      end
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      if (!vld) ok_vld = 1'b0;
      if (!in_rng(dh) || !in_rng(dl)) ok_rng = 1'b0;
      if (done != (k == P)) ok_done = 1'b0;
      qa = qa * 16 + 4 * longint'(dh) + longint'(dl);
    end
    chk(ok_vld, chained ? "R9 chained start pairs" : "R2 pair valid", 128'(ok_vld), 128'(1));
    chk(ok_rng, "R3 digit range", {dh, dl}, 128'(0));
    chk(ok_done, "R4 done on last pair", 128'(done), 128'(1));
    num  = 128'(x) << (4 * P - 2);
    qref = num / 128'(d);
    prod = 128'(qa) * 128'(d);
    rem  = $signed(num) - $signed(prod);
    nexp = rem < 0;
    chk((128'(qa) - 128'(neg)) == qref, poke ? "R7 quotient after ignored start" : "R5 quotient",
        128'(qa) - 128'(neg), qref);
    chk(neg == nexp, "R6 remainder sign", 128'(neg), 128'(nexp));
    mag = nexp ? 128'(-rem) : 128'(rem);
    chk(mag * 3 <= 128'(d) * 2, "R8 final remainder bound", mag, 128'(d));
    if (x == '0) chk(qa == 0 && !neg, "R10 zero dividend", 128'(qa), 128'(0));
    if (!hold) begin
      @(posedge clk); @(negedge clk);
      chk(!vld && !done, poke ? "R7 no extra operation" : "R4 idle after done",
          {vld, done}, 128'(0));
    end
  endtask

  function automatic logic [W-1:0] rnd56();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[W-1:0];
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] xr, dr;
    void'($urandom(32'd4217));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!vld && !done, "R1 reset outputs", {vld, done}, 128'(0));
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(!vld && !done, "R1 idle after reset", {vld, done}, 128'(0));

    do_div({W{1'b1}}, {1'b1, {(W-1){1'b0}}}, 1'b0, 1'b0, 1'b0);
    do_div({1'b1, {(W-1){1'b0}}}, {W{1'b1}}, 1'b0, 1'b0, 1'b0);
    do_div({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b0, 1'b0, 1'b0);
    do_div({W{1'b1}}, {W{1'b1}}, 1'b0, 1'b0, 1'b0);
    do_div('0, {1'b1, {(W-1){1'b0}}}, 1'b0, 1'b0, 1'b0);
    do_div('0, {W{1'b1}}, 1'b0, 1'b0, 1'b0);
    do_div(56'h1, {W{1'b1}}, 1'b0, 1'b0, 1'b0);
    do_div(56'hAAAAAAAAAAAAAA, 56'hC0000000000001, 1'b1, 1'b0, 1'b0);
    do_div(56'h9E3779B97F4A7C, 56'hB504F333F9DE64, 1'b0, 1'b0, 1'b1);
    do_div(56'hFEDCBA98765432, 56'h80000000000001, 1'b0, 1'b1, 1'b1);
    do_div(56'h123456789ABCDE, 56'hFFFFFFFFFFFFFE, 1'b0, 1'b1, 1'b0);

    for (int i = 0; i < 240; i++) begin
      xr = rnd56();
      dr = rnd56();
      dr[W-1] = 1'b1;
      if (i % 2 == 0) xr[W-1] = 1'b1;
      do_div(xr, dr, (i % 7) == 3, 1'b0, (i % 5) == 1);
    end
    finish_run();
  end
endmodule